// File: doc/BRIEF.md
# Switchable-Order Sinc Decimation Filter

This block turns the one-bit output of a sigma-delta modulator into signed 24-bit words. It is a cascaded integrator-comb filter whose order is chosen at run time between three and four. Each incoming bit is treated as +1 or -1 and fed into a bank of integrators. Once per decimation period, a chain of comb stages differences the sampled integrator value. The decimation period is 64 modulator samples times a 10-bit rate code. The block makes its own modulator sample strobe by dividing the master clock by 16, and it drives that strobe out so the modulator can present a new bit in step with it.

Results leave on a valid/ready stream. A word stays presented, unchanged, until the consumer takes it. If a later word finishes while one is still waiting, the later word is thrown away and the waiting word is kept. When the consumer holds ready high, each word shows up as a one-cycle valid pulse. Two behaviours are available after a restart. In the normal mode every period yields a word, including the partly settled words at the start. In zero-latency mode nothing is emitted until N full periods have passed for order N, so every word that comes out is fully settled. A restart pulse, or any change to the order, rate code or mode inputs, clears the whole filter and starts the settling count again.

Top module: `sinc_decim`

## Requirements
- R1: While reset is active and right after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: `mod_tick` is high for one cycle in every 16 clock cycles, counted from reset or from the last clear. `mod_bit` is sampled only in tick cycles: 1 counts as +1 and 0 counts as -1.
- R3: With `sinc3_sel` at 0 the filter is fourth order, and this is also the reset state. With `sinc3_sel` at 1 it is third order.
- R4: One result is produced per 64*FS ticks, where FS is `rate_code` and a code of 0 acts as 1. In the normal mode, successive valid pulses are 16*64*FS clock cycles apart.
- R5: `out_data` is the two's-complement full-precision result times 2^(22-G), where G = N*(6 + ceil(log2 FS)). A constant input of 1 therefore settles to (64*FS)^N scaled the same way. The magnitude of `out_data` never exceeds 2^22.
- R6: For a constant input, the N-th result and every later one equal the exact settled value. An input that alternates bit by bit settles to 0.
- R7: In the normal mode (`zero_lat` = 0), the first result after a restart is still emitted. It has the same sign as the settled value and a smaller magnitude.
- R8: In zero-latency mode (`zero_lat` = 1), no result appears earlier than 16*N*64*FS cycles after a clear. The first word appears at that point and is already settled, and later words follow every period.
- R9: A `restart` pulse, or a change on `sinc3_sel`, `rate_code` or `zero_lat`, clears the integrators, the comb delays, the sample divider and the settling count. Results in flight from the old setting are discarded.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value. Results that finish during such a stall are dropped. With `out_ready` at 1, `out_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Clears filter state and restarts settling |
| sinc3_sel | input | 1 | 0 selects fourth order, 1 selects third order |
| rate_code | input | 10 | Decimation multiplier FS (period is 64*FS samples) |
| zero_lat | input | 1 | 1 suppresses results until fully settled |
| mod_tick | output | 1 | Modulator sample strobe, one cycle in 16 |
| mod_bit | input | 1 | Modulator bitstream, sampled in tick cycles |
| out_valid | output | 1 | Result word is presented |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_data | output | 24 | Signed, scaled result word |

## Verification
The bench drives constant-one, constant-zero and alternating bitstreams under both orders and several rate codes, including code 0. It checks that the first normal-mode word is partial but has the correct sign, and that the N-th word is exact. A design that ran the wrong number of comb stages, or scaled with the wrong shift, would give a settled value off by a power of two or a wrong magnitude. A design that counted the settling periods wrongly in zero-latency mode would emit a word too early or too late, both after a restart and after a configuration change made with no restart. Under a stalled consumer the bench checks that the first word is held and that the words finishing meanwhile are dropped rather than overwriting it.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

  localparam int DEF_DIV       = 16;
  localparam int DEF_BASE_DEC  = 64;
  localparam int DEF_RATE_W    = 10;
  localparam int DEF_OUT_W     = 24;
  localparam int DEF_ORDER_MAX = 4;

  // smallest r with 2**r >= v
  function automatic int clog2i(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) begin
      if ((32'sd1 << i) < v) r = i + 1;
    end
    return r;
  endfunction

  typedef enum logic {
    ORD_HIGH = 1'b0,
    ORD_LOW  = 1'b1
  } order_sel_e;

endpackage

// File: rtl/sinc_rate_ctrl.sv
module sinc_rate_ctrl #(
  parameter int DIV       = sinc_pkg::DEF_DIV,
  parameter int BASE_DEC  = sinc_pkg::DEF_BASE_DEC,
  parameter int RATE_W    = sinc_pkg::DEF_RATE_W,
  parameter int ORDER_MAX = sinc_pkg::DEF_ORDER_MAX,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              order_low,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              zero_lat,
  output logic              clear,
  output logic              tick,
  output logic              dec_ev,
  output logic              emit
);

  localparam int DW = (sinc_pkg::clog2i(DIV) < 1) ? 1 : sinc_pkg::clog2i(DIV);
  localparam int SW = sinc_pkg::clog2i(ORDER_MAX + 1);

  logic [DW-1:0]     div_cnt;
  logic [CNT_W-1:0]  smp_cnt;
  logic [CNT_W-1:0]  dec_len;
  logic [RATE_W-1:0] fs_eff;
  logic [SW-1:0]     settle;
  logic [SW-1:0]     order_n;
  logic              last_smp;

  logic              ord_q;
  logic [RATE_W-1:0] rate_q;
  logic              zl_q;

  // configuration snapshot: any difference forces a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q  <= 1'b0;
      rate_q <= '0;
      zl_q   <= 1'b0;
    end else begin
      ord_q  <= order_low;
      rate_q <= rate_code;
      zl_q   <= zero_lat;
    end
  end

  assign clear = restart | (order_low != ord_q) | (rate_code != rate_q) | (zero_lat != zl_q);

  assign fs_eff   = (rate_code == '0) ? RATE_W'(1) : rate_code;
  assign dec_len  = CNT_W'(fs_eff) * CNT_W'(BASE_DEC);
  assign last_smp = (smp_cnt == dec_len - CNT_W'(1));
  assign tick     = (div_cnt == DW'(DIV - 1));
  assign order_n  = order_low ? SW'(ORDER_MAX - 1) : SW'(ORDER_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      smp_cnt <= '0;
      dec_ev  <= 1'b0;
      settle  <= '0;
    end else if (clear) begin
      div_cnt <= '0;
      smp_cnt <= '0;
      dec_ev  <= 1'b0;
      settle  <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + DW'(1);
      dec_ev  <= tick & last_smp;
      if (tick) smp_cnt <= last_smp ? '0 : smp_cnt + CNT_W'(1);
      if (dec_ev && settle < order_n) settle <= settle + SW'(1);
    end
  end

  assign emit = dec_ev & ~clear & (~zero_lat | (settle >= order_n - SW'(1)));

endmodule

// File: rtl/sinc_integ_bank.sv
module sinc_integ_bank #(
  parameter int ACC_W     = 65,
  parameter int ORDER_MAX = sinc_pkg::DEF_ORDER_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             bit_in,
  input  logic             order_low,
  output logic [ACC_W-1:0] tap
);

  logic [ORDER_MAX-1:0][ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;

  // +1 for a one, -1 (all ones) for a zero
  assign step = bit_in ? ACC_W'(1) : '1;

  for (genvar g = 0; g < ORDER_MAX; g++) begin : g_stage
    logic [ACC_W-1:0] addend;
    if (g == 0) begin : g_first
      assign addend = step;
    end else begin : g_rest
      assign addend = acc[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc[g] <= '0;
      else if (clear)  acc[g] <= '0;
      else if (tick)   acc[g] <= acc[g] + addend;
    end
  end

  assign tap = order_low ? acc[ORDER_MAX-2] : acc[ORDER_MAX-1];

endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
  parameter int ACC_W     = 65,
  parameter int ORDER_MAX = sinc_pkg::DEF_ORDER_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             dec_ev,
  input  logic             order_low,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] res
);

  logic [ORDER_MAX:0][ACC_W-1:0]   stg;
  logic [ORDER_MAX-1:0][ACC_W-1:0] dly;

  assign stg[0] = din;

  for (genvar g = 0; g < ORDER_MAX; g++) begin : g_comb
    assign stg[g+1] = stg[g] - dly[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly[g] <= '0;
      else if (clear)  dly[g] <= '0;
      else if (dec_ev) dly[g] <= stg[g];
    end
  end

  assign res = order_low ? stg[ORDER_MAX-1] : stg[ORDER_MAX];

endmodule

// File: rtl/sinc_out_scale.sv
module sinc_out_scale #(
  parameter int ACC_W     = 65,
  parameter int OUT_W     = sinc_pkg::DEF_OUT_W,
  parameter int RATE_W    = sinc_pkg::DEF_RATE_W,
  parameter int BASE_LOG  = 6,
  parameter int ORDER_MAX = sinc_pkg::DEF_ORDER_MAX
) (
  input  logic              order_low,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [ACC_W-1:0]  full,
  output logic [OUT_W-1:0]  word
);

  int fs;
  int lg;
  int gain_log;
  int sh;
  logic signed [ACC_W-1:0] v;

  always_comb begin
    fs = (rate_code == '0) ? 1 : int'(rate_code);
    lg = 0;
    for (int i = 0; i < RATE_W; i++) begin
      if ((32'sd1 << i) < fs) lg = i + 1;
    end
    gain_log = (order_low ? ORDER_MAX - 1 : ORDER_MAX) * (BASE_LOG + lg);
    // two bits of headroom: sign plus an exact power-of-two full scale
    sh = gain_log - (OUT_W - 2);
    v  = signed'(full);
    if (sh >= 0) v = v >>> sh;
    else         v = v <<< (-sh);
    word = v[OUT_W-1:0];
  end

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int DIV       = sinc_pkg::DEF_DIV,
  parameter int BASE_DEC  = sinc_pkg::DEF_BASE_DEC,
  parameter int RATE_W    = sinc_pkg::DEF_RATE_W,
  parameter int OUT_W     = sinc_pkg::DEF_OUT_W,
  parameter int ORDER_MAX = sinc_pkg::DEF_ORDER_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              sinc3_sel,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              zero_lat,
  output logic              mod_tick,
  input  logic              mod_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data
);

  localparam int CNT_W    = sinc_pkg::clog2i(BASE_DEC * ((1 << RATE_W) - 1));
  localparam int ACC_W    = 1 + ORDER_MAX * CNT_W;
  localparam int BASE_LOG = sinc_pkg::clog2i(BASE_DEC);

  sinc_pkg::order_sel_e order_sel;
  logic             order_low;
  logic             clear;
  logic             dec_ev;
  logic             emit;
  logic [ACC_W-1:0] integ_tap;
  logic [ACC_W-1:0] comb_res;
  logic [OUT_W-1:0] scaled;
  logic             take;

  assign order_sel = sinc_pkg::order_sel_e'(sinc3_sel);
  assign order_low = (order_sel == sinc_pkg::ORD_LOW);

  sinc_rate_ctrl #(
    .DIV(DIV), .BASE_DEC(BASE_DEC), .RATE_W(RATE_W),
    .ORDER_MAX(ORDER_MAX), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .order_low(order_low),
    .rate_code(rate_code), .zero_lat(zero_lat), .clear(clear),
    .tick(mod_tick), .dec_ev(dec_ev), .emit(emit)
  );

  sinc_integ_bank #(.ACC_W(ACC_W), .ORDER_MAX(ORDER_MAX)) u_integ (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tick(mod_tick),
    .bit_in(mod_bit), .order_low(order_low), .tap(integ_tap)
  );

  sinc_comb_chain #(.ACC_W(ACC_W), .ORDER_MAX(ORDER_MAX)) u_comb (
    .clk(clk), .rst_n(rst_n), .clear(clear), .dec_ev(dec_ev),
    .order_low(order_low), .din(integ_tap), .res(comb_res)
  );

  sinc_out_scale #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .RATE_W(RATE_W),
    .BASE_LOG(BASE_LOG), .ORDER_MAX(ORDER_MAX)
  ) u_scale (
    .order_low(order_low), .rate_code(rate_code),
    .full(comb_res), .word(scaled)
  );

  // a new word is taken only when the output slot is free or being drained
  assign take = emit & (~out_valid | out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= scaled;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
  parameter int DIV       = 16,
  parameter int BASE_DEC  = 64,
  parameter int RATE_W    = 10,
  parameter int OUT_W     = 24,
  parameter int ORDER_MAX = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              sinc3_sel,
  input logic [RATE_W-1:0] rate_code,
  input logic              zero_lat,
  input logic              mod_tick,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data
);

  logic              p_ord;
  logic [RATE_W-1:0] p_rate;
  logic              p_zl;
  logic              wipe;
  logic [31:0]       since;
  logic [31:0]       gap;
  logic [31:0]       need;
  int                fs_c;

  assign wipe = restart | (sinc3_sel != p_ord) | (rate_code != p_rate) | (zero_lat != p_zl);
  assign fs_c = (rate_code == '0) ? 1 : int'(rate_code);
  assign need = 32'((sinc3_sel ? ORDER_MAX - 1 : ORDER_MAX) * DIV * BASE_DEC * fs_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ord  <= 1'b0;
      p_rate <= '0;
      p_zl   <= 1'b0;
      since  <= '0;
      gap    <= '0;
    end else begin
      p_ord  <= sinc3_sel;
      p_rate <= rate_code;
      p_zl   <= zero_lat;
      since  <= wipe ? '0 : ((since == 32'hFFFF_FFFF) ? since : since + 32'd1);
      gap    <= (wipe || mod_tick) ? '0 : gap + 32'd1;
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    mod_tick == (gap == 32'(DIV - 1))); // R2

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mod_tick |=> !mod_tick); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid); // R10

  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_data) <= $signed(OUT_W'(1) << (OUT_W - 2)) &&
                   $signed(out_data) >= -$signed(OUT_W'(1) << (OUT_W - 2)))); // R5

  AST_ZL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_lat && $rose(out_valid)) |-> (since >= need)); // R8

endmodule

bind sinc_decim sinc_decim_chk #(
  .DIV(DIV), .BASE_DEC(BASE_DEC), .RATE_W(RATE_W),
  .OUT_W(OUT_W), .ORDER_MAX(ORDER_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .sinc3_sel(sinc3_sel),
  .rate_code(rate_code), .zero_lat(zero_lat), .mod_tick(mod_tick),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sinc_decim_tb.sv
module sinc_decim_tb;

  localparam int CLK_P = 10;
  localparam int FULL  = 4194304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        sinc3_sel = 1'b0;
  logic [9:0]  rate_code = 10'd1;
  logic        zero_lat = 1'b0;
  logic        mod_bit = 1'b0;
  logic        out_ready = 1'b1;
  logic        mod_tick;
  logic        out_valid;
  logic [23:0] out_data;

  int  cyc = 0;
  int  pat = 1;
  bit  alt = 1'b0;
  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  int  t0 = 0;

  sinc_decim u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sinc3_sel(sinc3_sel),
    .rate_code(rate_code), .zero_lat(zero_lat), .mod_tick(mod_tick),
    .mod_bit(mod_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bit source: 0 constant zero, 1 constant one, 2 toggles every sample
  always @(negedge clk) begin
    if (pat == 2) begin
      if (mod_tick) begin
        mod_bit = alt;
        alt = ~alt;
      end
    end else begin
      mod_bit = (pat == 1);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(input int limit, output bit got, output int stamp, output int data);
    got = 1'b0; stamp = 0; data = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1'b1; stamp = cyc; data = int'($signed(out_data));
        break;
      end
    end
  endtask

  task automatic configure(input bit s3, input int fs, input bit zl, input bit pulse);
    @(negedge clk);
    sinc3_sel = s3; rate_code = 10'(fs); zero_lat = zl; restart = pulse;
    @(negedge clk);
    restart = 1'b0;
    t0 = cyc;
  endtask

  task automatic t_reset();
    int a;
    int b;
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(out_data == '0, "R1", "data in reset", out_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    chk(out_data == '0, "R1", "data after reset", out_data, 0);
    while (!mod_tick) @(negedge clk);
    a = cyc;
    @(negedge clk);
    chk(mod_tick == 1'b0, "R2", "tick width", mod_tick, 0);
    while (!mod_tick) @(negedge clk);
    b = cyc;
    chk(b - a == 16, "R2", "tick spacing", b - a, 16);
  endtask

  // normal mode: partial first word, exact from the N-th on, fixed spacing
  task automatic t_settle(input bit s3, input int fs, input int p, input int expv);
    int n = s3 ? 3 : 4;
    int r = 64 * ((fs == 0) ? 1 : fs);
    int prev = 0;
    bit got; int st; int d;
    pat = p;
    configure(s3, fs, 1'b0, 1'b1);
    for (int k = 1; k <= n + 1; k++) begin
      wait_valid(16 * r + 50, got, st, d);
      chk(got, "R4", "word arrives each period", got, 1);
      if (!got) return;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10", "one-cycle strobe", out_valid, 0);
      if (k == 1) begin
        chk((expv > 0) ? (d > 0 && d < expv) : (d < 0 && d > expv), "R7",
            "first word partial, same sign", d, expv);
      end else begin
        chk(st - prev == 16 * r, "R4", "period spacing", st - prev, 16 * r);
      end
      if (k >= n) chk(d == expv, "R6", "settled value", d, expv);
      prev = st;
    end
  endtask

  // zero-latency: first word only after N periods, already settled
  task automatic t_zero_lat(input bit s3, input int fs, input int p, input int expv);
    int n = s3 ? 3 : 4;
    int r = 64 * ((fs == 0) ? 1 : fs);
    bit got; int st; int d; int st2; int d2;
    pat = p;
    configure(s3, fs, 1'b1, 1'b1);
    wait_valid(16 * n * r + 50, got, st, d);
    chk(got && (st - t0 >= 16 * n * r) && (st - t0 <= 16 * n * r + 2), "R8",
        s3 ? "first word after 3 periods (R3 order)" : "first word after 4 periods (R3 order)",
        st - t0, 16 * n * r + 1);
    chk(d == expv, "R8", "first word settled", d, expv);
    wait_valid(16 * r + 50, got, st2, d2);
    chk(got && (st2 - st == 16 * r), "R8", "next word one period later", st2 - st, 16 * r);
    chk(d2 == expv, "R8", "next word settled", d2, expv);
  endtask

  // configuration change with no restart pulse still clears and re-settles
  task automatic t_cfg_change();
    bit got; int st; int d;
    pat = 1;
    configure(1'b1, 1, 1'b1, 1'b1);
    repeat (2000) @(negedge clk);
    configure(1'b1, 2, 1'b1, 1'b0);
    wait_valid(16 * 3 * 128 + 50, got, st, d);
    chk(got && (st - t0 >= 16 * 3 * 128) && (st - t0 <= 16 * 3 * 128 + 2), "R9",
        "first word after change", st - t0, 16 * 3 * 128 + 1);
    chk(d == FULL, "R9", "value after change", d, FULL);
  endtask

  // stalled consumer: first word held, later words dropped
  task automatic t_backpressure();
    bit got; int st; int d; int d1;
    bit held = 1'b1;
    pat = 1;
    out_ready = 1'b0;
    configure(1'b1, 1, 1'b0, 1'b1);
    wait_valid(1100, got, st, d1);
    chk(got, "R10", "word under stall", got, 1);
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      if (!out_valid || int'($signed(out_data)) != d1) held = 1'b0;
    end
    chk(held, "R10", "held word unchanged", int'($signed(out_data)), d1);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "accepted word leaves", out_valid, 0);
    wait_valid(1100, got, st, d);
    chk(got && d == FULL, "R10", "next word is fresh", d, FULL);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_settle(1'b0, 1, 1, FULL);          // R3 order 4, R5 full scale
    t_settle(1'b1, 3, 0, -1769472);      // R2 zero maps to -1, R5 scaling
    t_settle(1'b0, 3, 1, 1327104);       // R5 non-power-of-two rate
    t_settle(1'b0, 0, 1, FULL);          // R4 code 0 acts as 1
    t_zero_lat(1'b1, 1, 1, FULL);        // R3 order 3
    t_zero_lat(1'b0, 1, 1, FULL);        // R3 order 4
    t_zero_lat(1'b0, 2, 2, 0);           // R6 alternating input
    t_cfg_change();
    t_backpressure();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule